// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles the outcome of a conditional branch in a small integer pipeline. It receives the instruction fields of one branch, the address of that branch and the values of its two source registers. From these it decides whether control transfers and, if it does, where to. A nonzero target is produced only for a taken branch. Every output that a branch never uses, such as the memory-side and writeback data, is held at zero. Register write data is one such output.

The instruction is presented in the slices that the unit actually reads. Those slices are the 7-bit major opcode in bits [6:0], the 3-bit condition selector in bits [14:12], the upper slice in bits [31:25] and the lower slice in bits [11:7]. The unit rebuilds the 13-bit signed offset from the upper and lower slices.

Inputs are captured on one clock edge. The decision is formed combinationally from the captured values. The decision is registered on the next edge, so a result appears two rising edges after its operands are applied. An active-low synchronous reset clears both register stages.

Top module: `branch_resolver`

## Requirements
- R1: With opcode 1100011 and selector 000, the branch is taken exactly when the two source values are equal.
- R2: With opcode 1100011 and selector 001, the branch is taken exactly when the two source values differ.
- R3: Selector 100 takes the branch when the first value is less than the second, read as two's-complement signed. Selector 101 takes it when the first is greater than or equal to the second, also signed.
- R4: Selector 110 takes the branch when the first value is less than the second, read as unsigned. Selector 111 takes it when the first is greater than or equal to the second, also unsigned.
- R5: Selectors 010 and 011 never take the branch. Any opcode other than 1100011 never takes it either.
- R6: When the branch is taken, the target equals the branch address plus an offset, with the sum wrapping modulo 2^32. The offset is imm[12] = inst[31], imm[11] = inst[7], imm[10:5] = inst[30:25] and imm[4:1] = inst[11:8], with imm[0] = 0, sign-extended from bit 12.
- R7: When the branch is not taken, the target output is all zeros.
- R8: The hold flag, the memory write enable, both memory addresses, the memory write data and the register write data are always zero.
- R9: A result appears two rising edges after its inputs are applied. While reset is low, and on the first result after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 7 | Instruction bits [6:0] |
| funct3_i | input | 3 | Instruction bits [14:12], condition selector |
| imm_hi_i | input | 7 | Instruction bits [31:25] |
| imm_lo_i | input | 5 | Instruction bits [11:7] |
| pc_i | input | 32 | Address of the branch |
| rs1_i | input | 32 | First source value |
| rs2_i | input | 32 | Second source value |
| take_o | output | 1 | Branch taken |
| target_o | output | 32 | Target address, zero when not taken |
| hold_o | output | 1 | Pipeline hold request, always low |
| mem_we_o | output | 1 | Memory write enable, always low |
| mem_raddr_o | output | 32 | Memory read address, always zero |
| mem_waddr_o | output | 32 | Memory write address, always zero |
| mem_wdata_o | output | 32 | Memory write data, always zero |
| rd_wdata_o | output | 32 | Register write data, always zero |

## Verification
The condition decision and the target addition both fall in the same cycle. A taken branch must therefore show a correct flag and a correct sum together, and a not-taken branch must show a zero address. The stimulus provokes this case with branches whose address sits near 0xFFFFFFF0 while the offset is positive, so that the sum wraps. It also uses operand pairs that straddle the sign boundary, such as 0x80000000 against 0x7FFFFFFF, where the signed and unsigned compares disagree. A behavioural model with a two-entry queue computes the flag and the target from the offset that the stimulus encoded. Its results are compared with the outputs on every clock.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      op_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      imm_hi_i,
  input  logic [4:0]      imm_lo_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            take_o,
  output logic [XLEN-1:0] target_o,
  output logic            hold_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_raddr_o,
  output logic [XLEN-1:0] mem_waddr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic [XLEN-1:0] rd_wdata_o
);
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam int         SEXT      = XLEN - 12;

  logic [6:0]      op_q;
  logic [2:0]      f3_q;
  logic [6:0]      hi_q;
  logic [4:0]      lo_q;
  logic [XLEN-1:0] pc_q, a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0;
      f3_q <= '0;
      hi_q <= '0;
      lo_q <= '0;
      pc_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      op_q <= op_i;
      f3_q <= funct3_i;
      hi_q <= imm_hi_i;
      lo_q <= imm_lo_i;
      pc_q <= pc_i;
      a_q  <= rs1_i;
      b_q  <= rs2_i;
    end
  end

  logic [XLEN-1:0] offset;
  assign offset = {{SEXT{hi_q[6]}}, lo_q[0], hi_q[5:0], lo_q[4:1], 1'b0};

  logic is_branch, eq, lt_s, lt_u;
  assign is_branch = (op_q == OP_BRANCH);
  assign eq   = (a_q == b_q);
  assign lt_s = ($signed(a_q) < $signed(b_q));
  assign lt_u = (a_q < b_q);

  logic cond;
  always_comb begin
    case (f3_q)
      3'b000:  cond = eq;
      3'b001:  cond = !eq;
      3'b100:  cond = lt_s;
      3'b101:  cond = !lt_s;
      3'b110:  cond = lt_u;
      3'b111:  cond = !lt_u;
      default: cond = 1'b0;
    endcase
  end

  logic            take_c;
  logic [XLEN-1:0] target_c;
  assign take_c   = is_branch && cond;
  assign target_c = take_c ? (pc_q + offset) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o   <= 1'b0;
      target_o <= '0;
    end else begin
      take_o   <= take_c;
      target_o <= target_c;
    end
  end

  assign hold_o      = 1'b0;
  assign mem_we_o    = 1'b0;
  assign mem_raddr_o = '0;
  assign mem_waddr_o = '0;
  assign mem_wdata_o = '0;
  assign rd_wdata_o  = '0;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [6:0]      op_i,
  input logic [2:0]      funct3_i,
  input logic [6:0]      imm_hi_i,
  input logic [4:0]      imm_lo_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic            take_o,
  input logic [XLEN-1:0] target_o
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end
  logic live;
  assign live = (seen == 2'd2);

  logic [XLEN-1:0] ofs_now;
  assign ofs_now = {{(XLEN-12){imm_hi_i[6]}}, imm_lo_i[0], imm_hi_i[5:0], imm_lo_i[4:1], 1'b0};

  p_beq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_i, 2) == 7'b1100011 && $past(funct3_i, 2) == 3'b000)
      |-> (take_o == ($past(rs1_i, 2) == $past(rs2_i, 2))));

  p_bltu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_i, 2) == 7'b1100011 && $past(funct3_i, 2) == 3'b110)
      |-> (take_o == ($past(rs1_i, 2) < $past(rs2_i, 2))));

  p_not_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(op_i, 2) != 7'b1100011) |-> !take_o);

  p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && take_o) |-> (target_o == $past(pc_i + ofs_now, 2)));

  p_zero_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (target_o == '0));
endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .funct3_i(funct3_i),
  .imm_hi_i(imm_hi_i), .imm_lo_i(imm_lo_i), .pc_i(pc_i),
  .rs1_i(rs1_i), .rs2_i(rs2_i), .take_o(take_o), .target_o(target_o)
);

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  op_i = '0;
  logic [2:0]  funct3_i = '0;
  logic [6:0]  imm_hi_i = '0;
  logic [4:0]  imm_lo_i = '0;
  logic [31:0] pc_i = '0, rs1_i = '0, rs2_i = '0;
  logic        take_o, hold_o, mem_we_o;
  logic [31:0] target_o, mem_raddr_o, mem_waddr_o, mem_wdata_o, rd_wdata_o;

  always #5 clk = ~clk;

  branch_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .funct3_i(funct3_i),
    .imm_hi_i(imm_hi_i), .imm_lo_i(imm_lo_i), .pc_i(pc_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .take_o(take_o), .target_o(target_o),
    .hold_o(hold_o), .mem_we_o(mem_we_o), .mem_raddr_o(mem_raddr_o),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o), .rd_wdata_o(rd_wdata_o)
  );

  int checks = 0, fails = 0;
  bit exp_take_q[$];
  logic [31:0] exp_tgt_q[$];
  string tag_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic side_zero(input string req);
    chk(req, {31'd0, hold_o}, 32'd0);
    chk(req, {31'd0, mem_we_o}, 32'd0);
    chk(req, mem_raddr_o | mem_waddr_o, 32'd0);
    chk(req, mem_wdata_o | rd_wdata_o, 32'd0);
  endtask

  // compare then drive one operation, at a falling edge
  task automatic step(input logic [6:0] op, input logic [2:0] f3, input int signed off,
                      input logic [31:0] pc, input logic [31:0] a, input logic [31:0] b);
    logic [12:0] im;
    bit t;
    string tg;
    @(negedge clk);
    if (exp_tag_ready()) begin
      bit et;
      logic [31:0] ee;
      string s;
      et = exp_take_q.pop_front();
      ee = exp_tgt_q.pop_front();
      s  = tag_q.pop_front();
      chk(s, {31'd0, take_o}, {31'd0, et});
      chk(et ? "R6" : "R7", target_o, ee);
      side_zero("R8");
    end
    im = off[12:0];
    op_i = op; funct3_i = f3; pc_i = pc; rs1_i = a; rs2_i = b;
    imm_hi_i = {im[12], im[10:5]};
    imm_lo_i = {im[4:1], im[11]};
    t = 1'b0;
    tg = "R5";
    if (op == 7'b1100011) begin
      case (f3)
        3'b000: begin t = (a == b); tg = "R1"; end
        3'b001: begin t = (a != b); tg = "R2"; end
        3'b100: begin t = ($signed(a) < $signed(b)); tg = "R3"; end
        3'b101: begin t = ($signed(a) >= $signed(b)); tg = "R3"; end
        3'b110: begin t = (a < b); tg = "R4"; end
        3'b111: begin t = (a >= b); tg = "R4"; end
        default: t = 1'b0;
      endcase
    end
    exp_take_q.push_back(t);
    exp_tgt_q.push_back(t ? pc + 32'(off) : 32'd0);
    tag_q.push_back(tg);
  endtask

  function automatic bit exp_tag_ready();
    return exp_take_q.size() == 2;
  endfunction

  localparam logic [6:0] BR = 7'b1100011;

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    rs1_i = 32'h5; rs2_i = 32'h5; op_i = BR; pc_i = 32'h100; imm_hi_i = 7'h0; imm_lo_i = 5'h4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", {31'd0, take_o}, 32'd0);
    chk("R9", target_o, 32'd0);
    side_zero("R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", {31'd0, take_o}, 32'd0);
    chk("R9", target_o, 32'd0);
    // directed cases
    step(BR, 3'b000, 16, 32'h0000_1000, 32'h1234, 32'h1234);
    step(BR, 3'b000, 16, 32'h0000_1000, 32'h1234, 32'h1235);
    step(BR, 3'b001, -8, 32'h0000_2000, 32'h1, 32'h2);
    step(BR, 3'b001, -8, 32'h0000_2000, 32'h7, 32'h7);
    step(BR, 3'b100, 4094, 32'h0000_0400, 32'h8000_0000, 32'h7FFF_FFFF);
    step(BR, 3'b101, -4096, 32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF);
    step(BR, 3'b110, 100, 32'h0000_0400, 32'h8000_0000, 32'h7FFF_FFFF);
    step(BR, 3'b111, 100, 32'h0000_0400, 32'h8000_0000, 32'h7FFF_FFFF);
    step(BR, 3'b101, 2, 32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(BR, 3'b111, 2, 32'h10, 32'h0, 32'h0);
    step(BR, 3'b000, 64, 32'hFFFF_FFF0, 32'h9, 32'h9);
    step(BR, 3'b001, -4096, 32'h0000_0800, 32'h1, 32'h0);
    step(BR, 3'b010, 32, 32'h100, 32'h3, 32'h3);
    step(BR, 3'b011, 32, 32'h100, 32'h3, 32'h4);
    step(7'b1101111, 3'b000, 32, 32'h100, 32'h3, 32'h3);
    step(7'b0110011, 3'b001, 32, 32'h100, 32'h3, 32'h4);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b, pc;
      logic [2:0] f3;
      int signed off;
      a  = $urandom;
      b  = ($urandom_range(0, 3) == 0) ? a : 32'($urandom);
      if ($urandom_range(0, 3) == 0) b = {~a[31], b[30:0]};
      pc = $urandom;
      f3 = 3'($urandom_range(0, 7));
      off = $urandom_range(0, 8191) - 4096;
      off = off & ~1;
      step(($urandom_range(0, 9) == 0) ? 7'($urandom) : BR, f3, off, pc, a, b);
    end
    step(7'h0, 3'b0, 0, 32'h0, 32'h0, 32'h1);
    step(7'h0, 3'b0, 0, 32'h0, 32'h0, 32'h1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule